// File: doc/BRIEF.md
# Multi-Address SMBus Register Mapper

This block sits behind an SMBus bit-level shifter and turns already decoded transactions into register accesses. One target answers at three 7-bit addresses: a main address and two auxiliary temperature-sensor addresses. All three come from register fields, and either auxiliary address can be switched off. Each transaction arrives as a single-cycle strobe carrying a target address, a transaction kind, a command byte and up to sixteen bits of write data. Exactly two clock cycles later the block returns a response strobe with a match flag and read data. When the match flag is low, the shifter should NACK.

The matched address picks the register bank. The main address always works on the 256-entry main bank. The two auxiliary addresses each own an eight-entry sensor bank. Byte reads at an auxiliary address reach that bank through command indices 0x50 to 0x5F. Word commands at an auxiliary address use the low two command bits to select a fixed pair of sensor registers, with a fixed byte order. Three main-bank indices are held in flops because they act on the block: the control register at 0x40, the main-address register at 0x48 and the auxiliary-address configuration at 0x4A.

Top module: `smbmap_top`

## Requirements
- R1: After reset the main address is 0x2D and the auxiliary configuration is 0x01, so the first auxiliary address is 0x49 and the second is 0x48. Byte reads of indices 0x48, 0x4A and 0x40 return 0x2D, 0x01 and 0x08. Every sensor-bank entry reads 0. No response strobe is seen before the first transaction.
- R2: A bank-0 write to index 0x48 stores the byte. The main address then becomes bits 6:0 of that byte, and it changes through no other path.
- R3: In configuration index 0x4A, bits 2:0 place the first auxiliary address at 0x48 plus the field and bit 3 disables it. Bits 6:4 and bit 7 do the same for the second auxiliary address. A transaction whose address equals no enabled slot returns match 0 and data 0, and it changes no state.
- R4: When slots share an address, the main slot is chosen first and the first auxiliary slot second.
- R5: Kind 0 (send-byte) loads the 8-bit register pointer from the command field. Kind 1 (receive-byte) reads the index held in the pointer, using the bank that a byte-command read at the same address would use.
- R6: Kind 3 (byte-command read) at the first or second auxiliary address, with an index from 0x50 to 0x5F, returns entry index[2:0] of sensor bank 1 or bank 2. Every other byte read uses bank 0. Kind 2 (byte-command write) always writes bank 0 with write data bits 7:0, at any address.
- R7: Kind 5 (word read) at an auxiliary address uses command bits 1:0 to select a sensor pair: 0 gives entries 0 and 1, 1 gives entry 2 alone (configuration), 2 gives entries 3 and 4, 3 gives entries 5 and 6. The first entry is returned in data bits 7:0 and the second in bits 15:8. For configuration the single byte fills both halves.
- R8: Kind 4 (word write) at an auxiliary address writes data bits 15:8 to the first entry of the pair and bits 7:0 to the second. A configuration write stores bits 7:0 only.
- R9: At the main address, a word read returns the bank-0 byte at the command index in both halves, and a word write stores data bits 7:0 there.
- R10: A bank-0 write to index 0x40 with bit 7 set reloads the configuration to 0x01 and the control register to 0x08, and clears both sensor banks. The main address and all other bank-0 contents are kept. Without bit 7 the byte is stored in the control register.
- R11: Each transaction strobe is answered by a one-cycle response strobe two clock edges later. A byte read returns its byte in data bits 7:0 with bits 15:8 zero. Writes, send-byte and the unused kinds 6 and 7 return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | One-cycle strobe for a decoded transaction |
| txn_addr | input | 7 | Target address of the transaction |
| txn_kind | input | 3 | Transaction kind, encoded as in R5 to R11 |
| txn_cmd | input | 8 | Command byte, or the byte carried by a send-byte |
| txn_wdata | input | 16 | Write data for byte and word writes |
| rsp_valid | output | 1 | Response strobe, two cycles after txn_valid |
| rsp_match | output | 1 | High when an enabled slot claimed the address |
| rsp_rdata | output | 16 | Read data, zero for non-read responses |

## Verification
The bench first sets up the two sensor slots at the same address, then moves the main address onto them, and checks that a priority swap would send word data to the wrong bank. It switches each slot off through bits 3 and 7 and probes the old address. A design that ignores the disable bits would acknowledge that address, and a design that skips the gate would still write through it. It writes word pairs with distinct high and low bytes and reads them back, which exposes a swapped byte order and a configuration access that writes or returns the wrong half. It then triggers the initialization bit and checks that the main address survives while the configuration and sensor banks revert, and it mixes these cases with random traffic checked against a bench model.

// File: rtl/smbmap_pkg.sv
package smbmap_pkg;

  // bank-0 indices with side effects on the block
  localparam logic [7:0] REG_CTRL      = 8'h40;
  localparam logic [7:0] REG_MAIN_ADDR = 8'h48;
  localparam logic [7:0] REG_AUX_CFG   = 8'h4A;
  // upper nibble of the index window that reaches a sensor bank
  localparam logic [3:0] AUX_WINDOW    = 4'h5;
  localparam int         INIT_BIT      = 7;
  localparam int         NUM_AUX       = 2;
  localparam int         PAIR_IDX_W    = 3;

  typedef enum logic [2:0] {
    K_SEND = 3'd0,
    K_RECV = 3'd1,
    K_WRB  = 3'd2,
    K_RDB  = 3'd3,
    K_WRW  = 3'd4,
    K_RDW  = 3'd5,
    K_RSV6 = 3'd6,
    K_RSV7 = 3'd7
  } txn_kind_e;

  typedef enum logic [1:0] {
    SLOT_NONE,
    SLOT_MAIN,
    SLOT_AUX1,
    SLOT_AUX2
  } slot_e;

  typedef enum logic [1:0] {
    RSP_ZERO,
    RSP_BYTE,
    RSP_DUP,
    RSP_PAIR
  } rsp_mode_e;

  typedef enum logic [1:0] {
    SRC_RAM,
    SRC_FLOP,
    SRC_AUX
  } byte_src_e;

  // sensor pair selected by a word command's low two bits
  function automatic logic [PAIR_IDX_W-1:0] pair_first(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd0;
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic [PAIR_IDX_W-1:0] pair_second(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  function automatic logic pair_single(input logic [1:0] sel);
    return sel == 2'd1;
  endfunction

endpackage

// File: rtl/smbmap_match.sv
module smbmap_match
  import smbmap_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] AUX_BASE = 7'h48
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] main_addr,
  input  logic [7:0]        aux_cfg,
  output slot_e             slot
);

  logic [NUM_AUX-1:0] aux_hit;

  for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
    logic [2:0]        field;
    logic              off;
    logic [ADDR_W-1:0] slot_addr;
    assign field     = aux_cfg[4*g +: 3];
    assign off       = aux_cfg[4*g + 3];
    assign slot_addr = AUX_BASE + ADDR_W'(field);
    assign aux_hit[g] = !off && (addr == slot_addr);
  end

  always_comb begin
    if (addr == main_addr)  slot = SLOT_MAIN;
    else if (aux_hit[0])    slot = SLOT_AUX1;
    else if (aux_hit[1])    slot = SLOT_AUX2;
    else                    slot = SLOT_NONE;
  end

endmodule

// File: rtl/smbmap_ram.sv
module smbmap_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/smbmap_auxbank.sv
module smbmap_auxbank #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int NRD    = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       we_a,
  input  logic [IDX_W-1:0]           idx_a,
  input  logic [DATA_W-1:0]          dat_a,
  input  logic                       we_b,
  input  logic [IDX_W-1:0]           idx_b,
  input  logic [DATA_W-1:0]          dat_b,
  input  logic [NRD-1:0][IDX_W-1:0]  ridx,
  output logic [NRD-1:0][DATA_W-1:0] rdat
);

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      if (we_a) regs[idx_a] <= dat_a;
      if (we_b) regs[idx_b] <= dat_b;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdat[r] = regs[ridx[r]];
  end

endmodule

// File: rtl/smbmap_top.sv
module smbmap_top
  import smbmap_pkg::*;
#(
  parameter int                ADDR_W        = 7,
  parameter int                IDX_W         = 8,
  parameter int                DATA_W        = 8,
  parameter int                AUX_DEPTH     = 8,
  parameter logic [DATA_W-1:0] MAIN_ADDR_RST = 8'h2D,
  parameter logic [ADDR_W-1:0] AUX_BASE      = 7'h48,
  parameter logic [DATA_W-1:0] AUX_CFG_RST   = 8'h01,
  parameter logic [DATA_W-1:0] CTRL_RST      = 8'h08
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                txn_valid,
  input  logic [ADDR_W-1:0]   txn_addr,
  input  logic [2:0]          txn_kind,
  input  logic [IDX_W-1:0]    txn_cmd,
  input  logic [2*DATA_W-1:0] txn_wdata,
  output logic                rsp_valid,
  output logic                rsp_match,
  output logic [2*DATA_W-1:0] rsp_rdata
);

  localparam int AUX_IDX_W = $clog2(AUX_DEPTH);
  localparam int NRD       = 3;

  // control state
  logic [DATA_W-1:0] main_raw;
  logic [ADDR_W-1:0] main_addr;
  logic [DATA_W-1:0] aux_cfg;
  logic [DATA_W-1:0] ctrl;
  logic [IDX_W-1:0]  ptr;

  assign main_addr = main_raw[ADDR_W-1:0];

  txn_kind_e kind;
  slot_e     slot;
  logic      hit;
  logic      is_main;
  logic      aux_sel;

  assign kind    = txn_kind_e'(txn_kind);
  assign hit     = txn_valid && (slot != SLOT_NONE);
  assign is_main = (slot == SLOT_MAIN);
  assign aux_sel = (slot == SLOT_AUX2);

  smbmap_match #(
    .ADDR_W   (ADDR_W),
    .AUX_BASE (AUX_BASE)
  ) i_match (
    .addr      (txn_addr),
    .main_addr (main_addr),
    .aux_cfg   (aux_cfg),
    .slot      (slot)
  );

  // ---------------- write side ----------------
  logic              b0_we;
  logic [DATA_W-1:0] b0_dat;
  logic              init_req;
  logic              auxw;
  logic [1:0]        psel;

  assign b0_we    = hit && ((kind == K_WRB) || ((kind == K_WRW) && is_main));
  assign b0_dat   = txn_wdata[DATA_W-1:0];
  assign init_req = b0_we && (txn_cmd == REG_CTRL) && b0_dat[INIT_BIT];
  assign auxw     = hit && (kind == K_WRW) && !is_main;
  assign psel     = txn_cmd[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      main_raw <= MAIN_ADDR_RST;
      aux_cfg  <= AUX_CFG_RST;
      ctrl     <= CTRL_RST;
      ptr      <= '0;
    end else begin
      if (hit && (kind == K_SEND)) ptr <= txn_cmd;
      if (b0_we) begin
        case (txn_cmd)
          REG_MAIN_ADDR: main_raw <= b0_dat;
          REG_AUX_CFG:   aux_cfg  <= b0_dat;
          REG_CTRL: begin
            if (b0_dat[INIT_BIT]) begin
              ctrl    <= CTRL_RST;
              aux_cfg <= AUX_CFG_RST;
            end else begin
              ctrl <= b0_dat;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- storage ----------------
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] ram_rd;

  assign rd_idx = (kind == K_RECV) ? ptr : txn_cmd;

  smbmap_ram #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) i_ram (
    .clk   (clk),
    .we    (b0_we),
    .waddr (txn_cmd),
    .wdata (b0_dat),
    .raddr (rd_idx),
    .rdata (ram_rd)
  );

  logic [NRD-1:0][AUX_IDX_W-1:0] bank_ridx;
  logic [NRD-1:0][DATA_W-1:0]    bank_rdat [NUM_AUX];

  assign bank_ridx[0] = rd_idx[AUX_IDX_W-1:0];
  assign bank_ridx[1] = AUX_IDX_W'(pair_first(psel));
  assign bank_ridx[2] = AUX_IDX_W'(pair_second(psel));

  for (genvar g = 0; g < NUM_AUX; g++) begin : g_bank
    logic sel_me;
    assign sel_me = auxw && (aux_sel == 1'(g));
    smbmap_auxbank #(
      .DEPTH  (AUX_DEPTH),
      .DATA_W (DATA_W),
      .NRD    (NRD)
    ) i_bank (
      .clk   (clk),
      .rst   (rst),
      .clr   (init_req),
      .we_a  (sel_me),
      .idx_a (AUX_IDX_W'(pair_first(psel))),
      .dat_a (pair_single(psel) ? txn_wdata[DATA_W-1:0] : txn_wdata[2*DATA_W-1:DATA_W]),
      .we_b  (sel_me && !pair_single(psel)),
      .idx_b (AUX_IDX_W'(pair_second(psel))),
      .dat_b (txn_wdata[DATA_W-1:0]),
      .ridx  (bank_ridx),
      .rdat  (bank_rdat[g])
    );
  end

  // ---------------- read side, stage 1 ----------------
  logic [NRD-1:0][DATA_W-1:0] sel_rdat;
  logic [DATA_W-1:0]          flop_val;
  logic                       flop_hit;
  logic                       in_window;
  rsp_mode_e                  mode_c;
  byte_src_e                  src_c;

  assign sel_rdat  = aux_sel ? bank_rdat[1] : bank_rdat[0];
  assign in_window = (rd_idx[IDX_W-1:IDX_W-4] == AUX_WINDOW);

  always_comb begin
    flop_hit = 1'b1;
    case (rd_idx)
      REG_CTRL:      flop_val = ctrl;
      REG_MAIN_ADDR: flop_val = main_raw;
      REG_AUX_CFG:   flop_val = aux_cfg;
      default: begin
        flop_val = '0;
        flop_hit = 1'b0;
      end
    endcase
  end

  always_comb begin
    mode_c = RSP_ZERO;
    src_c  = flop_hit ? SRC_FLOP : SRC_RAM;
    if (hit) begin
      case (kind)
        K_RECV, K_RDB: begin
          mode_c = RSP_BYTE;
          if (!is_main && in_window) src_c = SRC_AUX;
        end
        K_RDW: mode_c = is_main ? RSP_DUP : RSP_PAIR;
        default: mode_c = RSP_ZERO;
      endcase
    end
  end

  logic              s1_valid;
  logic              s1_match;
  rsp_mode_e         s1_mode;
  byte_src_e         s1_src;
  logic [DATA_W-1:0] s1_flop;
  logic [DATA_W-1:0] s1_auxb;
  logic [DATA_W-1:0] s1_lo;
  logic [DATA_W-1:0] s1_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_match <= 1'b0;
      s1_mode  <= RSP_ZERO;
      s1_src   <= SRC_RAM;
      s1_flop  <= '0;
      s1_auxb  <= '0;
      s1_lo    <= '0;
      s1_hi    <= '0;
    end else begin
      s1_valid <= txn_valid;
      s1_match <= hit;
      s1_mode  <= mode_c;
      s1_src   <= src_c;
      s1_flop  <= flop_val;
      s1_auxb  <= sel_rdat[0];
      s1_lo    <= sel_rdat[1];
      s1_hi    <= sel_rdat[2];
    end
  end

  // ---------------- stage 2, registered response ----------------
  logic [DATA_W-1:0] s1_byte;

  always_comb begin
    case (s1_src)
      SRC_FLOP: s1_byte = s1_flop;
      SRC_AUX:  s1_byte = s1_auxb;
      default:  s1_byte = ram_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_match <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_match <= s1_valid && s1_match;
      case (s1_mode)
        RSP_BYTE: rsp_rdata <= {{DATA_W{1'b0}}, s1_byte};
        RSP_DUP:  rsp_rdata <= {s1_byte, s1_byte};
        RSP_PAIR: rsp_rdata <= {s1_hi, s1_lo};
        default:  rsp_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/smbmap_checker.sv
module smbmap_checker #(
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] AUX_BASE = 7'h48
) (
  input logic              clk,
  input logic              rst,
  input logic              txn_valid,
  input logic [ADDR_W-1:0] txn_addr,
  input logic [ADDR_W-1:0] main_addr,
  input logic [7:0]        aux_cfg,
  input logic              rsp_valid,
  input logic              rsp_match,
  input logic [15:0]       rsp_rdata
);

  logic [ADDR_W-1:0] aux1_addr;
  logic [ADDR_W-1:0] aux2_addr;
  logic              claimed;

  assign aux1_addr = AUX_BASE + ADDR_W'(aux_cfg[2:0]);
  assign aux2_addr = AUX_BASE + ADDR_W'(aux_cfg[6:4]);
  assign claimed   = (txn_addr == main_addr) ||
                     (!aux_cfg[3] && txn_addr == aux1_addr) ||
                     (!aux_cfg[7] && txn_addr == aux2_addr);

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    txn_valid |=> ##1 rsp_valid) else $error("response strobe missing"); // R11

  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !txn_valid |=> ##1 !rsp_valid) else $error("spurious response"); // R11

  AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_match) |-> (rsp_rdata == 16'h0000)) else $error("data on NACK"); // R3

  AST_UNCLAIMED_NACK: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && !claimed) |=> ##1 (rsp_valid && !rsp_match)) else $error("unclaimed address matched"); // R3

  AST_MAIN_ACK: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_addr == main_addr) |=> ##1 rsp_match) else $error("main address not matched"); // R4

  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !txn_valid |=> $stable(main_addr)) else $error("main address moved without a write"); // R2

endmodule

bind smbmap_top smbmap_checker #(
  .ADDR_W   (ADDR_W),
  .AUX_BASE (AUX_BASE)
) i_checker (
  .clk       (clk),
  .rst       (rst),
  .txn_valid (txn_valid),
  .txn_addr  (txn_addr),
  .main_addr (main_addr),
  .aux_cfg   (aux_cfg),
  .rsp_valid (rsp_valid),
  .rsp_match (rsp_match),
  .rsp_rdata (rsp_rdata)
);

// File: tb/test_smbmap_top.sv
`timescale 1ns/1ps
module test_smbmap_top;

  localparam logic [2:0] T_SEND = 3'd0, T_RECV = 3'd1, T_WRB = 3'd2,
                         T_RDB  = 3'd3, T_WRW  = 3'd4, T_RDW = 3'd5;

  logic        clk = 1'b0;
  logic        rst;
  logic        txn_valid;
  logic [6:0]  txn_addr;
  logic [2:0]  txn_kind;
  logic [7:0]  txn_cmd;
  logic [15:0] txn_wdata;
  logic        rsp_valid;
  logic        rsp_match;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  smbmap_top i_smbmap_top (
    .clk       (clk),
    .rst       (rst),
    .txn_valid (txn_valid),
    .txn_addr  (txn_addr),
    .txn_kind  (txn_kind),
    .txn_cmd   (txn_cmd),
    .txn_wdata (txn_wdata),
    .rsp_valid (rsp_valid),
    .rsp_match (rsp_match),
    .rsp_rdata (rsp_rdata)
  );

  // bench model
  logic [7:0] m_b0  [256];
  logic [7:0] m_aux [2][8];
  logic [7:0] m_main, m_cfg, m_ctrl, m_ptr;

  function automatic int m_slot(input logic [6:0] a);
    if (a == m_main[6:0]) return 1;
    if (!m_cfg[3] && a == 7'h48 + {4'd0, m_cfg[2:0]}) return 2;
    if (!m_cfg[7] && a == 7'h48 + {4'd0, m_cfg[6:4]}) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] m_rd0(input logic [7:0] i);
    if (i == 8'h40) return m_ctrl;
    if (i == 8'h48) return m_main;
    if (i == 8'h4A) return m_cfg;
    return m_b0[i];
  endfunction

  function automatic int first_of(input logic [1:0] s);
    int t[4] = '{0, 2, 3, 5};
    return t[s];
  endfunction

  function automatic int second_of(input logic [1:0] s);
    int t[4] = '{1, 2, 4, 6};
    return t[s];
  endfunction

  task automatic m_wr0(input logic [7:0] i, input logic [7:0] d);
    m_b0[i] = d;
    if (i == 8'h48) m_main = d;
    else if (i == 8'h4A) m_cfg = d;
    else if (i == 8'h40) begin
      if (d[7]) begin
        m_ctrl = 8'h08;
        m_cfg  = 8'h01;
        for (int b = 0; b < 2; b++)
          for (int e = 0; e < 8; e++) m_aux[b][e] = 8'h00;
      end else m_ctrl = d;
    end
  endtask

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_txn(input string tag, input logic [6:0] a, input logic [2:0] k,
                        input logic [7:0] c, input logic [15:0] w);
    int          s;
    logic [15:0] ed;
    logic [7:0]  idx, b;
    s  = m_slot(a);
    ed = 16'h0000;
    if (s != 0) begin
      case (k)
        T_SEND: m_ptr = c;
        T_RECV, T_RDB: begin
          idx = (k == T_RECV) ? m_ptr : c;
          if (s >= 2 && idx[7:4] == 4'h5) b = m_aux[s-2][idx[2:0]];
          else b = m_rd0(idx);
          ed = {8'h00, b};
        end
        T_WRB: m_wr0(c, w[7:0]);
        T_RDW: begin
          if (s == 1) ed = {m_rd0(c), m_rd0(c)};
          else ed = {m_aux[s-2][second_of(c[1:0])], m_aux[s-2][first_of(c[1:0])]};
        end
        T_WRW: begin
          if (s == 1) m_wr0(c, w[7:0]);
          else if (c[1:0] == 2'd1) m_aux[s-2][2] = w[7:0];
          else begin
            m_aux[s-2][first_of(c[1:0])]  = w[15:8];
            m_aux[s-2][second_of(c[1:0])] = w[7:0];
          end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    txn_valid = 1'b1; txn_addr = a; txn_kind = k; txn_cmd = c; txn_wdata = w;
    @(negedge clk);
    txn_valid = 1'b0;
    @(negedge clk);
    chk(tag, {rsp_valid, rsp_match, rsp_rdata}, {1'b1, s != 0, ed});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    rst = 1'b1; txn_valid = 1'b0; txn_addr = '0; txn_kind = '0; txn_cmd = '0; txn_wdata = '0;
    m_main = 8'h2D; m_cfg = 8'h01; m_ctrl = 8'h08; m_ptr = 8'h00;
    for (int b = 0; b < 2; b++) for (int e = 0; e < 8; e++) m_aux[b][e] = 8'h00;
    for (int i = 0; i < 256; i++) m_b0[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1", {rsp_valid, rsp_match, rsp_rdata}, 18'h0);

    // R1 reset values
    do_txn("R1", 7'h2D, T_RDB, 8'h48, 16'h0);
    do_txn("R1", 7'h2D, T_RDB, 8'h4A, 16'h0);
    do_txn("R1", 7'h2D, T_RDB, 8'h40, 16'h0);
    do_txn("R1", 7'h49, T_RDW, 8'h00, 16'h0);
    do_txn("R1", 7'h48, T_RDW, 8'h03, 16'h0);

    // fill bank 0 (skipping the side-effect indices)
    for (int i = 0; i < 256; i++)
      if (i != 8'h40 && i != 8'h48 && i != 8'h4A)
        do_txn("R6", 7'h2D, T_WRB, 8'(i), {8'h00, 8'(i) ^ 8'h5A});

    // R8 / R7 pair order and configuration half
    do_txn("R8", 7'h49, T_WRW, 8'h02, 16'hABCD);
    do_txn("R7", 7'h49, T_RDW, 8'h02, 16'h0);
    do_txn("R8", 7'h49, T_WRW, 8'h01, 16'h77EE);
    do_txn("R7", 7'h49, T_RDW, 8'h01, 16'h0);
    do_txn("R8", 7'h48, T_WRW, 8'h00, 16'h1357);
    do_txn("R7", 7'h48, T_RDW, 8'h00, 16'h0);
    do_txn("R7", 7'h49, T_RDW, 8'h00, 16'h0);

    // R6 bank choice for byte reads and bank-0 byte writes
    do_txn("R6", 7'h49, T_RDB, 8'h53, 16'h0);
    do_txn("R6", 7'h49, T_RDB, 8'h5B, 16'h0);
    do_txn("R6", 7'h48, T_RDB, 8'h51, 16'h0);
    do_txn("R6", 7'h49, T_WRB, 8'h53, 16'h00C3);
    do_txn("R6", 7'h2D, T_RDB, 8'h53, 16'h0);
    do_txn("R6", 7'h49, T_RDB, 8'h53, 16'h0);
    do_txn("R6", 7'h49, T_RDB, 8'h20, 16'h0);

    // R5 pointer
    do_txn("R5", 7'h49, T_SEND, 8'h52, 16'h0);
    do_txn("R5", 7'h49, T_RECV, 8'h00, 16'h0);
    do_txn("R5", 7'h2D, T_RECV, 8'h00, 16'h0);
    do_txn("R5", 7'h2D, T_SEND, 8'h4A, 16'h0);
    do_txn("R5", 7'h48, T_RECV, 8'h00, 16'h0);

    // R9 word at main
    do_txn("R9", 7'h2D, T_WRW, 8'h30, 16'h1122);
    do_txn("R9", 7'h2D, T_RDB, 8'h30, 16'h0);
    do_txn("R9", 7'h2D, T_RDW, 8'h30, 16'h0);

    // R11 unused kinds
    do_txn("R11", 7'h2D, 3'd6, 8'h30, 16'hFFFF);
    do_txn("R11", 7'h49, 3'd7, 8'h00, 16'hFFFF);

    // R4 priority: both aux at 0x48
    do_txn("R4", 7'h2D, T_WRB, 8'h4A, 16'h0000);
    do_txn("R4", 7'h48, T_WRW, 8'h03, 16'hBEEF);
    do_txn("R4", 7'h48, T_RDW, 8'h03, 16'h0);
    do_txn("R4", 7'h2D, T_WRB, 8'h4A, 16'h0070);
    do_txn("R4", 7'h4F, T_RDW, 8'h03, 16'h0);
    do_txn("R4", 7'h48, T_RDW, 8'h03, 16'h0);
    // R2 move main onto 0x48: main wins
    do_txn("R2", 7'h2D, T_WRB, 8'h48, 16'h00C8);
    do_txn("R2", 7'h2D, T_RDB, 8'h30, 16'h0);
    do_txn("R4", 7'h48, T_RDW, 8'h30, 16'h0);
    do_txn("R2", 7'h48, T_RDB, 8'h48, 16'h0);

    // R3 disable bits
    do_txn("R3", 7'h48, T_WRB, 8'h4A, 16'h00F9);
    do_txn("R3", 7'h49, T_WRW, 8'h00, 16'h4444);
    do_txn("R3", 7'h4F, T_RDW, 8'h00, 16'h0);
    do_txn("R3", 7'h48, T_WRB, 8'h4A, 16'h0071);
    do_txn("R3", 7'h49, T_RDW, 8'h00, 16'h0);
    do_txn("R3", 7'h10, T_WRB, 8'h31, 16'h00AA);
    do_txn("R3", 7'h48, T_RDB, 8'h31, 16'h0);

    // R10 initialization bit
    do_txn("R10", 7'h48, T_WRB, 8'h4A, 16'h0023);
    do_txn("R10", 7'h48, T_WRB, 8'h40, 16'h0015);
    do_txn("R10", 7'h48, T_RDB, 8'h40, 16'h0);
    do_txn("R10", 7'h48, T_WRB, 8'h40, 16'h0080);
    do_txn("R10", 7'h48, T_RDB, 8'h4A, 16'h0);
    do_txn("R10", 7'h48, T_RDB, 8'h40, 16'h0);
    do_txn("R10", 7'h48, T_RDB, 8'h30, 16'h0);
    do_txn("R10", 7'h49, T_RDW, 8'h01, 16'h0);
    do_txn("R10", 7'h2D, T_RDB, 8'h48, 16'h0);

    // random traffic
    for (int n = 0; n < 800; n++) begin
      logic [6:0]  a;
      logic [2:0]  k;
      logic [7:0]  c;
      string       tg;
      int          s;
      case ($urandom % 4)
        0: a = m_main[6:0];
        1: a = 7'h48 + {4'd0, m_cfg[2:0]};
        2: a = 7'h48 + {4'd0, m_cfg[6:4]};
        default: a = 7'($urandom);
      endcase
      k  = 3'($urandom);
      c  = 8'($urandom);
      s  = m_slot(a);
      if (s == 0) tg = "R3";
      else if (k == T_SEND || k == T_RECV) tg = "R5";
      else if (k == T_WRB || k == T_RDB) tg = "R6";
      else if (k == T_WRW) tg = (s == 1) ? "R9" : "R8";
      else if (k == T_RDW) tg = (s == 1) ? "R9" : "R7";
      else tg = "R11";
      do_txn(tg, a, k, c, 16'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule